// File: doc/BRIEF.md
# Serial UART with Selectable Hardware Handshaking

This block is the serial engine between a byte-wide transmit queue, a byte-wide receive queue and a two-wire asynchronous line. On the transmit side it takes a byte from the queue, frames it with a low start bit and one high stop bit, and shifts it out least significant bit first. Each bit lasts sixteen pulses of an oversampling tick that an external baud divider supplies. On the receive side it finds the falling edge of a start bit, samples every bit at the eighth tick of sixteen, and hands the assembled byte to the receive queue. Frames are either 7 or 8 data bits long.

Flow control is done entirely in logic. One of three handshakes can be selected: a request/clear pair, a ready pair, or in-band pause/resume characters carried on the data path. The same pair of outputs tells the far end whether the local receive queue is close to full. The block can hold its line low to send a break, and it reports a received break separately from framing errors. A transmit-enable output brackets each outgoing frame for a half-duplex differential driver. Two further modem inputs, carrier detect and ring, are resynchronised and passed through.

Top module: `hs_uart`

## Requirements
- R1: After reset, txd is high, txEn is low, txPop, rxPush, rxBreak and rxFrameErr are low, and rtsOut and dtrOut are high.
- R2: A popped byte is sent as one low start bit, then the data bits least significant first (8 bits, or the low 7 bits when cfgSevenBit is 1), then one high stop bit. Every bit lasts 16 tick16 pulses.
- R3: txEn rises in the cycle after txPop and stays high for one bit time (16 ticks, the first of which may be partial) before the start bit. It stays high through the stop bit and falls when the stop bit has completed.
- R4: The receiver samples each bit at the 8th tick after the start edge. It delivers the byte on rxData with a one-cycle rxPush pulse, and a 7-bit frame arrives zero-extended in bit 7. A low pulse shorter than half a bit is ignored.
- R5: A frame whose stop bit samples low and whose data bits are not all zero gives a one-cycle rxFrameErr pulse and no rxPush.
- R6: A frame that is low at every sample point, stop bit included, gives a one-cycle rxBreak pulse and neither rxPush nor rxFrameErr. The receiver then waits for the line to return high before it looks for a new start bit.
- R7: While cfgBreak is 1, txd is low and txEn is high, and no byte is popped.
- R8: With cfgFlowMode = 1 (request/clear), a new byte is popped only while ctsIn is high, rtsOut equals the inverse of rxAlmostFull, and dtrOut is held high.
- R9: With cfgFlowMode = 2 (ready pair), a new byte is popped only while dsrIn is high, dtrOut equals the inverse of rxAlmostFull, and rtsOut is held high.
- R10: With cfgFlowMode = 3 (in-band), a received 0x13 stops new transmissions and a received 0x11 lets them resume, and neither character is pushed. In the other modes (0 = no flow control) both are ordinary data. In modes 0 and 3, rtsOut and dtrOut are high.
- R11: dcdOut and riOut follow dcdIn and riIn after the two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle oversampling pulse, 16 per bit |
| cfgSevenBit | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfgFlowMode | input | 2 | 0 none, 1 request/clear, 2 ready pair, 3 in-band |
| cfgBreak | input | 1 | Force the line low (send break) |
| txValid | input | 1 | Transmit queue holds a byte |
| txData | input | 8 | Byte at the head of the transmit queue |
| txPop | output | 1 | Byte taken from the transmit queue this cycle |
| txd | output | 1 | Serial transmit line |
| txEn | output | 1 | Transmit enable for a half-duplex driver |
| rxd | input | 1 | Serial receive line |
| rxData | output | 8 | Received byte |
| rxPush | output | 1 | Write rxData into the receive queue |
| rxFrameErr | output | 1 | Stop bit was low |
| rxBreak | output | 1 | Break received |
| rxAlmostFull | input | 1 | Receive queue is near full |
| ctsIn | input | 1 | Clear-to-send from the far end |
| dsrIn | input | 1 | Data-set-ready from the far end |
| dcdIn | input | 1 | Carrier detect |
| riIn | input | 1 | Ring indicator |
| rtsOut | output | 1 | Request-to-send to the far end |
| dtrOut | output | 1 | Data-terminal-ready to the far end |
| dcdOut | output | 1 | Synchronised carrier detect |
| riOut | output | 1 | Synchronised ring indicator |

## Verification
The bench uses the default parameters: 8-bit data width, 16 ticks per bit and two synchroniser stages. It pulses tick16 every fourth clock, so one bit is exactly 64 clocks. This makes it cheap to decode every outgoing bit at mid-bit, to bound the partial first tick of the enable lead time, and to run both word lengths and every flow mode in one short run. The two-stage synchroniser keeps the handshake inputs' delay small enough that the pop can be awaited right after a line is raised.

// File: rtl/hs_uart_pkg.sv
package hs_uart_pkg;

  typedef enum logic [1:0] {
    FLOW_NONE    = 2'd0,
    FLOW_RTSCTS  = 2'd1,
    FLOW_DSRDTR  = 2'd2,
    FLOW_XONXOFF = 2'd3
  } flowMode_e;

  typedef enum logic [2:0] {
    TX_IDLE, TX_LEAD, TX_START, TX_DATA, TX_STOP
  } txState_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;    // load shifter, restart tx tick count
    logic txShift;   // advance to next data bit
    logic rxCntClr;  // restart rx tick count, arm zero tracking
    logic rxSample;  // shift current line level into rx shifter
  } dpStrobe_t;

  // timing and line status from datapath to control
  typedef struct packed {
    logic txBitEnd;
    logic rxMid;
    logic rxBitEnd;
    logic rxLine;
  } dpStatus_t;

endpackage

// File: rtl/hs_uart_dp.sv
module hs_uart_dp
  import hs_uart_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              sevenBit,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] txDataIn,
  input  logic              rxdIn,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              dcdIn,
  input  logic              riIn,
  output dpStatus_t         status,
  output logic              txBit,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxAllZero,
  output logic              ctsSync,
  output logic              dsrSync,
  output logic              dcdSync,
  output logic              riSync
);

  localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam int NSIG = 5;
  // the serial line idles high, modem inputs idle low
  localparam logic [NSIG-1:0] SYNC_RST = NSIG'(1);

  logic [NSIG-1:0] rawIn;
  logic [NSIG-1:0] syncOut;
  assign rawIn = {riIn, dcdIn, dsrIn, ctsIn, rxdIn};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    logic [NSIG-1:0] q;
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) q <= SYNC_RST;
        else       q <= rawIn;
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) q <= SYNC_RST;
        else       q <= g_sync[s-1].q;
    end
  end
  assign syncOut = g_sync[SYNC_STAGES-1].q;

  assign ctsSync = syncOut[1];
  assign dsrSync = syncOut[2];
  assign dcdSync = syncOut[3];
  assign riSync  = syncOut[4];

  // tick counters
  logic [CNT_W-1:0] txCnt, rxCnt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              txCnt <= '0;
    else if (strobe.txLoad) txCnt <= '0;
    else if (tick)          txCnt <= (txCnt == CNT_LAST) ? '0 : txCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                rxCnt <= '0;
    else if (strobe.rxCntClr) rxCnt <= '0;
    else if (tick)            rxCnt <= (rxCnt == CNT_LAST) ? '0 : rxCnt + 1'b1;

  assign status.txBitEnd = tick && (txCnt == CNT_LAST);
  assign status.rxMid    = tick && (rxCnt == CNT_MID);
  assign status.rxBitEnd = tick && (rxCnt == CNT_LAST);
  assign status.rxLine   = syncOut[0];

  // shifters
  logic [DATA_W-1:0] txShreg, rxShreg;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               txShreg <= '0;
    else if (strobe.txLoad)  txShreg <= txDataIn;
    else if (strobe.txShift) txShreg <= {1'b0, txShreg[DATA_W-1:1]};

  assign txBit = txShreg[0];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                rxShreg <= '0;
    else if (strobe.rxSample) rxShreg <= {status.rxLine, rxShreg[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                                  rxAllZero <= 1'b1;
    else if (strobe.rxCntClr)                   rxAllZero <= 1'b1;
    else if (strobe.rxSample && status.rxLine)  rxAllZero <= 1'b0;

  // a short word lands in the upper bits of the shifter
  assign rxByte = sevenBit ? {1'b0, rxShreg[DATA_W-1:1]} : rxShreg;

endmodule

// File: rtl/hs_uart_ctrl.sv
module hs_uart_ctrl
  import hs_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [7:0] XON_CHAR  = 8'h11,
  parameter logic [7:0] XOFF_CHAR = 8'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sevenBit,
  input  flowMode_e         flowMode,
  input  logic              breakReq,
  input  logic              txValid,
  input  logic              rxAlmostFull,
  input  dpStatus_t         status,
  input  logic              txBit,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxAllZero,
  input  logic              ctsSync,
  input  logic              dsrSync,
  output dpStrobe_t         strobe,
  output logic              txPop,
  output logic              txd,
  output logic              txEn,
  output logic              rxPush,
  output logic              rxBreak,
  output logic              rxFrameErr,
  output logic              rtsOut,
  output logic              dtrOut
);

  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [DATA_W-1:0] XON_W  = DATA_W'(XON_CHAR);
  localparam logic [DATA_W-1:0] XOFF_W = DATA_W'(XOFF_CHAR);

  txState_e txState, txNext;
  rxState_e rxState, rxNext;
  logic [BIT_W-1:0] txIdx, rxIdx, lastIdx;
  logic paused, txAllow, txGo;
  logic stopMid, goodFrame, isXon, isXoff, ctrlChar;

  assign lastIdx = sevenBit ? BIT_W'(DATA_W - 2) : BIT_W'(DATA_W - 1);

  // ---------------- transmit ----------------
  always_comb begin
    case (flowMode)
      FLOW_RTSCTS:  txAllow = ctsSync;
      FLOW_DSRDTR:  txAllow = dsrSync;
      FLOW_XONXOFF: txAllow = !paused;
      default:      txAllow = 1'b1;
    endcase
  end

  assign txGo  = (txState == TX_IDLE) && txValid && txAllow && !breakReq;
  assign txPop = txGo;

  always_comb begin
    txNext         = txState;
    strobe.txLoad  = txGo;
    strobe.txShift = 1'b0;
    case (txState)
      TX_IDLE:  if (txGo) txNext = TX_LEAD;
      TX_LEAD:  if (status.txBitEnd) txNext = TX_START;
      TX_START: if (status.txBitEnd) txNext = TX_DATA;
      TX_DATA:  if (status.txBitEnd) begin
                  strobe.txShift = 1'b1;
                  if (txIdx == lastIdx) txNext = TX_STOP;
                end
      TX_STOP:  if (status.txBitEnd) txNext = TX_IDLE;
      default:  txNext = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      txState <= TX_IDLE;
      txIdx   <= '0;
    end else begin
      txState <= txNext;
      if (txState == TX_START && status.txBitEnd)     txIdx <= '0;
      else if (txState == TX_DATA && status.txBitEnd) txIdx <= txIdx + 1'b1;
    end

  always_comb begin
    if (breakReq) txd = 1'b0;
    else begin
      case (txState)
        TX_START: txd = 1'b0;
        TX_DATA:  txd = txBit;
        default:  txd = 1'b1;
      endcase
    end
  end

  assign txEn = (txState != TX_IDLE) || breakReq;

  // ---------------- receive ----------------
  always_comb begin
    rxNext          = rxState;
    strobe.rxCntClr = 1'b0;
    strobe.rxSample = 1'b0;
    case (rxState)
      RX_IDLE:  if (!status.rxLine) begin
                  strobe.rxCntClr = 1'b1;
                  rxNext = RX_START;
                end
      RX_START: if (status.rxMid && status.rxLine) rxNext = RX_IDLE;
                else if (status.rxBitEnd)          rxNext = RX_DATA;
      RX_DATA:  begin
                  strobe.rxSample = status.rxMid;
                  if (status.rxBitEnd && rxIdx == lastIdx) rxNext = RX_STOP;
                end
      RX_STOP:  if (status.rxMid) rxNext = status.rxLine ? RX_IDLE : RX_WAIT;
      RX_WAIT:  if (status.rxLine) rxNext = RX_IDLE;
      default:  rxNext = RX_IDLE;
    endcase
  end

  assign stopMid   = (rxState == RX_STOP) && status.rxMid;
  assign goodFrame = stopMid && status.rxLine;
  assign isXon     = (rxByte == XON_W);
  assign isXoff    = (rxByte == XOFF_W);
  assign ctrlChar  = (flowMode == FLOW_XONXOFF) && (isXon || isXoff);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxState    <= RX_IDLE;
      rxIdx      <= '0;
      rxPush     <= 1'b0;
      rxBreak    <= 1'b0;
      rxFrameErr <= 1'b0;
      paused     <= 1'b0;
    end else begin
      rxState    <= rxNext;
      if (rxState == RX_START && status.rxBitEnd)     rxIdx <= '0;
      else if (rxState == RX_DATA && status.rxBitEnd) rxIdx <= rxIdx + 1'b1;
      rxPush     <= goodFrame && !ctrlChar;
      rxBreak    <= stopMid && !status.rxLine && rxAllZero;
      rxFrameErr <= stopMid && !status.rxLine && !rxAllZero;
      if (flowMode != FLOW_XONXOFF)  paused <= 1'b0;
      else if (goodFrame && isXoff)  paused <= 1'b1;
      else if (goodFrame && isXon)   paused <= 1'b0;
    end

  // ---------------- handshake outputs ----------------
  assign rtsOut = (flowMode == FLOW_RTSCTS) ? !rxAlmostFull : 1'b1;
  assign dtrOut = (flowMode == FLOW_DSRDTR) ? !rxAlmostFull : 1'b1;

  // ---------------- assertions ----------------
  assert_line_low_enabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    !txd |-> txEn);

  assert_pop_starts_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    txPop |=> (txEn && txd));

  assert_break_holds_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> (!txd && !txPop));

  assert_cts_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode == FLOW_RTSCTS && txState == TX_IDLE && !ctsSync) |=> (txState == TX_IDLE));

  assert_dsr_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode == FLOW_DSRDTR && txState == TX_IDLE && !dsrSync) |=> (txState == TX_IDLE));

  assert_no_ctrl_push_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && $past(flowMode) == FLOW_XONXOFF) |-> (rxByte != XON_W && rxByte != XOFF_W));

  assert_rx_events_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxPush, rxBreak, rxFrameErr}));

endmodule

// File: rtl/hs_uart.sv
module hs_uart
  import hs_uart_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              cfgSevenBit,
  input  logic [1:0]        cfgFlowMode,
  input  logic              cfgBreak,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txPop,
  output logic              txd,
  output logic              txEn,
  input  logic              rxd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxPush,
  output logic              rxFrameErr,
  output logic              rxBreak,
  input  logic              rxAlmostFull,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              dcdIn,
  input  logic              riIn,
  output logic              rtsOut,
  output logic              dtrOut,
  output logic              dcdOut,
  output logic              riOut
);

  dpStrobe_t strobe;
  dpStatus_t status;
  logic txBit, rxAllZero, ctsSync, dsrSync;

  hs_uart_dp #(
    .DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick16), .sevenBit(cfgSevenBit),
    .strobe(strobe), .txDataIn(txData),
    .rxdIn(rxd), .ctsIn(ctsIn), .dsrIn(dsrIn), .dcdIn(dcdIn), .riIn(riIn),
    .status(status), .txBit(txBit), .rxByte(rxData), .rxAllZero(rxAllZero),
    .ctsSync(ctsSync), .dsrSync(dsrSync), .dcdSync(dcdOut), .riSync(riOut)
  );

  hs_uart_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sevenBit(cfgSevenBit),
    .flowMode(flowMode_e'(cfgFlowMode)), .breakReq(cfgBreak),
    .txValid(txValid), .rxAlmostFull(rxAlmostFull),
    .status(status), .txBit(txBit), .rxByte(rxData), .rxAllZero(rxAllZero),
    .ctsSync(ctsSync), .dsrSync(dsrSync),
    .strobe(strobe), .txPop(txPop), .txd(txd), .txEn(txEn),
    .rxPush(rxPush), .rxBreak(rxBreak), .rxFrameErr(rxFrameErr),
    .rtsOut(rtsOut), .dtrOut(dtrOut)
  );

endmodule

// File: tb/hs_uart_tb_top.sv
module hs_uart_tb_top;

  localparam int BIT_CLKS = 64;  // 16 ticks x 4 clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic cfgSevenBit = 1'b0;
  logic [1:0] cfgFlowMode = 2'd0;
  logic cfgBreak = 1'b0;
  logic txValid = 1'b0;
  logic [7:0] txData = 8'h00;
  logic rxd = 1'b1;
  logic rxAlmostFull = 1'b0;
  logic ctsIn = 1'b0, dsrIn = 1'b0, dcdIn = 1'b0, riIn = 1'b0;
  logic txPop, txd, txEn, rxPush, rxFrameErr, rxBreak, rtsOut, dtrOut, dcdOut, riOut;
  logic [7:0] rxData;

  int tests = 0;
  int fails = 0;
  int pushCnt = 0, ferrCnt = 0, brkCnt = 0, popCnt = 0;
  logic [7:0] lastRx = 8'h00;

  hs_uart dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .cfgSevenBit(cfgSevenBit),
    .cfgFlowMode(cfgFlowMode), .cfgBreak(cfgBreak), .txValid(txValid),
    .txData(txData), .txPop(txPop), .txd(txd), .txEn(txEn), .rxd(rxd),
    .rxData(rxData), .rxPush(rxPush), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak),
    .rxAlmostFull(rxAlmostFull), .ctsIn(ctsIn), .dsrIn(dsrIn), .dcdIn(dcdIn),
    .riIn(riIn), .rtsOut(rtsOut), .dtrOut(dtrOut), .dcdOut(dcdOut), .riOut(riOut)
  );

  initial forever #10 clk = ~clk;

  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      tick16 = (ph == 0);
    end
  end

  always @(posedge clk) begin
    if (rxPush) begin pushCnt <= pushCnt + 1; lastRx <= rxData; end
    if (rxFrameErr) ferrCnt <= ferrCnt + 1;
    if (rxBreak) brkCnt <= brkCnt + 1;
    if (txPop) popCnt <= popCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendRx(input logic [7:0] d, input int nb, input logic stopBit);
    rxd = 1'b0;
    waitClk(BIT_CLKS);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      waitClk(BIT_CLKS);
    end
    rxd = stopBit;
    waitClk(BIT_CLKS);
    rxd = 1'b1;
    waitClk(2 * BIT_CLKS);
  endtask

  // hand a byte to the DUT and decode the frame it sends
  task automatic txByte(input logic [7:0] d, input logic seven, input string req);
    int n, lead, nb;
    logic [7:0] got, expd;
    nb = seven ? 7 : 8;
    expd = seven ? {1'b0, d[6:0]} : d;
    got = 8'h00;
    txData = d;
    txValid = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!txPop && n < 4000);
    chk(txPop, req, "byte popped", int'(txPop), 1);
    @(negedge clk);
    txValid = 1'b0;
    chk(txEn == 1'b1, "R3", "txEn after pop", int'(txEn), 1);
    lead = 0;
    while (txd == 1'b1 && lead < 200) begin
      if (!txEn) break;
      lead++;
      @(negedge clk);
    end
    chk(lead >= 61 && lead <= 64, "R3", "enable lead clocks", lead, 64);
    waitClk(BIT_CLKS / 2);
    chk(txd == 1'b0, "R2", "start bit low", int'(txd), 0);
    for (int i = 0; i < nb; i++) begin
      waitClk(BIT_CLKS);
      got[i] = txd;
    end
    chk(got == expd, req, "tx data bits", int'(got), int'(expd));
    waitClk(BIT_CLKS);
    chk(txd == 1'b1, "R2", "stop bit high", int'(txd), 1);
    chk(txEn == 1'b1, "R3", "txEn during stop", int'(txEn), 1);
    waitClk(40);
    chk(txEn == 1'b0, "R3", "txEn after stop", int'(txEn), 0);
  endtask

  // rx vectors: {seven, mode, data, stop, kind, expected}
  // kind 0 push, 1 swallowed, 2 framing error, 3 break
  localparam logic [21:0] RXV [12] = '{
    {1'b0, 2'd0, 8'hA5, 1'b1, 2'd0, 8'hA5},
    {1'b0, 2'd0, 8'h3C, 1'b1, 2'd0, 8'h3C},
    {1'b1, 2'd0, 8'hC5, 1'b1, 2'd0, 8'h45},
    {1'b0, 2'd0, 8'h13, 1'b1, 2'd0, 8'h13},
    {1'b0, 2'd3, 8'h13, 1'b1, 2'd1, 8'h00},
    {1'b0, 2'd3, 8'h11, 1'b1, 2'd1, 8'h00},
    {1'b1, 2'd3, 8'h11, 1'b1, 2'd1, 8'h00},
    {1'b0, 2'd3, 8'h41, 1'b1, 2'd0, 8'h41},
    {1'b0, 2'd0, 8'h55, 1'b0, 2'd2, 8'h00},
    {1'b0, 2'd0, 8'h00, 1'b0, 2'd3, 8'h00},
    {1'b1, 2'd0, 8'h00, 1'b0, 2'd3, 8'h00},
    {1'b0, 2'd0, 8'hFF, 1'b1, 2'd0, 8'hFF}
  };

  initial begin
    int p0, f0, b0, k0;
    logic [21:0] e;
    logic [1:0] kind;

    // R1 reset state
    waitClk(5);
    chk(txd == 1'b1 && txEn == 1'b0, "R1", "line idle in reset", {txd, txEn}, 2'b10);
    rstN = 1'b1;
    waitClk(5);
    chk(txd == 1'b1 && txEn == 1'b0 && txPop == 1'b0, "R1", "tx idle after reset",
        {txd, txEn, txPop}, 3'b100);
    chk(rxPush == 0 && rxBreak == 0 && rxFrameErr == 0, "R1", "rx strobes idle",
        {rxPush, rxBreak, rxFrameErr}, 0);
    chk(rtsOut && dtrOut, "R1", "handshake outputs", {rtsOut, dtrOut}, 2'b11);

    // table of receive vectors (R4 R5 R6 R10)
    for (int v = 0; v < 12; v++) begin
      e = RXV[v];
      cfgSevenBit = e[21];
      cfgFlowMode = e[20:19];
      kind = e[9:8];
      waitClk(4);
      p0 = pushCnt; f0 = ferrCnt; b0 = brkCnt;
      sendRx(e[18:11], e[21] ? 7 : 8, e[10]);
      chk((pushCnt - p0) == ((kind == 2'd0) ? 1 : 0),
          (kind == 2'd1) ? "R10" : "R4", "push count", pushCnt - p0, (kind == 2'd0) ? 1 : 0);
      if (kind == 2'd0)
        chk(lastRx == e[7:0], "R4", "rx data", int'(lastRx), int'(e[7:0]));
      chk((ferrCnt - f0) == ((kind == 2'd2) ? 1 : 0), "R5", "frame error count",
          ferrCnt - f0, (kind == 2'd2) ? 1 : 0);
      chk((brkCnt - b0) == ((kind == 2'd3) ? 1 : 0), "R6", "break count",
          brkCnt - b0, (kind == 2'd3) ? 1 : 0);
    end
    cfgSevenBit = 1'b0;
    cfgFlowMode = 2'd0;
    waitClk(4);

    // R4 short glitch ignored
    p0 = pushCnt; f0 = ferrCnt; b0 = brkCnt;
    rxd = 1'b0; waitClk(12); rxd = 1'b1;
    waitClk(4 * BIT_CLKS);
    chk(pushCnt == p0 && ferrCnt == f0 && brkCnt == b0, "R4", "glitch ignored",
        pushCnt - p0 + ferrCnt - f0 + brkCnt - b0, 0);

    // R2 R3 transmit frames
    txByte(8'hA5, 1'b0, "R2");
    cfgSevenBit = 1'b1;
    txByte(8'hDA, 1'b1, "R2");
    cfgSevenBit = 1'b0;

    // R8 request/clear
    cfgFlowMode = 2'd1;
    ctsIn = 1'b0;
    waitClk(4);
    k0 = popCnt;
    txData = 8'h33; txValid = 1'b1;
    waitClk(300);
    chk(popCnt == k0 && txEn == 1'b0, "R8", "held while cts low", popCnt - k0, 0);
    ctsIn = 1'b1;
    txByte(8'h33, 1'b0, "R8");
    rxAlmostFull = 1'b1; waitClk(2);
    chk(rtsOut == 1'b0 && dtrOut == 1'b1, "R8", "rts drops near full", {rtsOut, dtrOut}, 2'b01);
    rxAlmostFull = 1'b0; waitClk(2);
    chk(rtsOut == 1'b1, "R8", "rts restored", int'(rtsOut), 1);
    ctsIn = 1'b0;

    // R9 ready pair
    cfgFlowMode = 2'd2;
    dsrIn = 1'b0;
    waitClk(4);
    k0 = popCnt;
    txData = 8'h6E; txValid = 1'b1;
    waitClk(300);
    chk(popCnt == k0 && txEn == 1'b0, "R9", "held while dsr low", popCnt - k0, 0);
    dsrIn = 1'b1;
    txByte(8'h6E, 1'b0, "R9");
    rxAlmostFull = 1'b1; waitClk(2);
    chk(dtrOut == 1'b0 && rtsOut == 1'b1, "R9", "dtr drops near full", {rtsOut, dtrOut}, 2'b10);
    rxAlmostFull = 1'b0; dsrIn = 1'b0;

    // R10 in-band pause and resume
    cfgFlowMode = 2'd3;
    rxAlmostFull = 1'b1; waitClk(2);
    chk(rtsOut && dtrOut, "R10", "both high in in-band mode", {rtsOut, dtrOut}, 2'b11);
    rxAlmostFull = 1'b0;
    sendRx(8'h13, 8, 1'b1);
    k0 = popCnt;
    txData = 8'h77; txValid = 1'b1;
    waitClk(300);
    chk(popCnt == k0 && txEn == 1'b0, "R10", "paused after 0x13", popCnt - k0, 0);
    txValid = 1'b0;
    sendRx(8'h11, 8, 1'b1);
    txByte(8'h77, 1'b0, "R10");
    cfgFlowMode = 2'd0;

    // R7 break transmit
    waitClk(4);
    cfgBreak = 1'b1;
    k0 = popCnt;
    txValid = 1'b1; txData = 8'h01;
    waitClk(2);
    chk(txd == 1'b0 && txEn == 1'b1, "R7", "break drives line", {txd, txEn}, 2'b01);
    waitClk(200);
    chk(popCnt == k0 && txd == 1'b0, "R7", "no pop during break", popCnt - k0, 0);
    txValid = 1'b0;
    cfgBreak = 1'b0;
    waitClk(2);
    chk(txd == 1'b1 && txEn == 1'b0, "R7", "line released", {txd, txEn}, 2'b10);

    // R11 carrier and ring pass-through
    dcdIn = 1'b1; riIn = 1'b0; waitClk(4);
    chk(dcdOut == 1'b1 && riOut == 1'b0, "R11", "dcd follows", {dcdOut, riOut}, 2'b10);
    dcdIn = 1'b0; riIn = 1'b1; waitClk(4);
    chk(dcdOut == 1'b0 && riOut == 1'b1, "R11", "ri follows", {dcdOut, riOut}, 2'b01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R1-all: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule